// File: doc/BRIEF.md
# Capture FIFO with DMA Threshold

This block is a synchronous first-in first-out buffer of 128 words of 32 bits. It sits between the stage that packs captured pixel data into words and a bus reader that drains them. Words enter on a write strobe and leave on a read strobe. A read returns its word on `rdData` one cycle after the strobe. A write into a full buffer is dropped. A read from an empty buffer returns zero.

A DMA request is raised while DMA is enabled and the fill level is at or above a programmable threshold. The threshold code is held off by one, so a code of n asks for n+1 words. The write pointer, the read pointer, the current level and the highest level reached since reset are all visible on ports.

Five events are recorded as sticky pending bits: overflow, underflow, full, threshold reached and non-empty. Writing a one to a bit clears it. Each bit has its own enable, and the enabled pending bits are combined into one interrupt line.

Top module: `capture_fifo`

## Requirements
- R1: After reset, `level`, `wrPtr`, `rdPtr`, `peakLevel`, `evtPending`, `rdData`, `dmaReq` and `irq` are all zero.
- R2: Words leave in the order they were accepted. A read of a non-empty buffer puts its word on `rdData` after the next rising edge. `level` counts accepted words from 0 to 128, and a read and a write accepted in the same cycle leave `level` unchanged.
- R3: A write while `level` is 128 is dropped: `level` and `wrPtr` stay unchanged, the word is never read out, and pending bit 0 (overflow) is set.
- R4: A read while `level` is 0 loads zero into `rdData`, leaves `level` and `rdPtr` unchanged, and sets pending bit 1 (underflow).
- R5: `wrPtr` and `rdPtr` each advance by one per accepted write or read, and wrap from 127 to 0.
- R6: `peakLevel` holds the largest `level` reached since reset and never decreases.
- R7: `dmaReq` is high exactly when `dmaEnable` is 1 and `level` >= `thrCode` + 1. With `dmaEnable` at 0 it stays low.
- R8: Pending bit 2 (full: `level` = 128), bit 3 (threshold: `level` >= `thrCode` + 1, independent of `dmaEnable`) and bit 4 (non-empty: `level` > 0) are set at the rising edge after a cycle in which their condition holds.
- R9: At a rising edge, a pending bit is cleared when the matching `evtClear` bit is 1 and is left unchanged when it is 0. If the event occurs in the same cycle as its clear, the event takes priority and the bit stays set.
- R10: `irq` is 1 exactly when at least one bit is set in both `evtPending` and `evtEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Word to write |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Word from the last read; zero after an underflow |
| dmaEnable | input | 1 | Allows the DMA request |
| thrCode | input | 7 | Threshold code; the threshold is code + 1 words |
| dmaReq | output | 1 | DMA request |
| wrPtr | output | 7 | Write pointer |
| rdPtr | output | 7 | Read pointer |
| level | output | 8 | Words held |
| peakLevel | output | 8 | Highest level since reset |
| evtClear | input | 5 | Write-one-to-clear strobes for the pending bits |
| evtEnable | input | 5 | Per-event interrupt enable |
| evtPending | output | 5 | Pending bits: 0 overflow, 1 underflow, 2 full, 3 threshold, 4 non-empty |
| irq | output | 1 | Interrupt |

## Verification
The assertions check invariants on every cycle:
- the level stays within bounds;
- the gap between the pointers equals the level;
- the peak covers the level and never drops;
- a write into a full buffer and a read from an empty one leave the state alone;
- the DMA request stays low while DMA is disabled;
- pending bits stay set until cleared, and an event always sets its bit.

Only the bench's scenarios can show the rest:
- data ordering, including a simultaneous read and write;
- pointer wrap-around;
- the exact threshold boundary and the off-by-one code;
- the zero word returned on underflow;
- the same-cycle priority of an event over its clear;
- the masking of the interrupt.

// File: rtl/capture_fifo_pkg.sv
package capture_fifo_pkg;
  localparam int unsigned CF_DATA_W  = 32;
  localparam int unsigned CF_DEPTH   = 128;
  localparam int unsigned CF_THR_W   = 7;
  localparam int unsigned CF_NUM_EVT = 5;

  typedef enum int unsigned {
    EV_OVERFLOW  = 0,
    EV_UNDERFLOW = 1,
    EV_FULL      = 2,
    EV_THRESH    = 3,
    EV_NONEMPTY  = 4
  } evtIdx_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;      // accepted write
    logic pop;       // accepted read
    logic popEmpty;  // read of an empty buffer
  } dpStrobe_t;
endpackage

// File: rtl/capture_fifo_dp.sv
module capture_fifo_dp
  import capture_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = CF_DEPTH,
  parameter int unsigned DATA_W = CF_DATA_W,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [PTR_W-1:0]  wrAddr,
  input  logic [PTR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  // storage array: no reset, written only on an accepted write
  always_ff @(posedge clk) begin
    if (strobe.push) store[wrAddr] <= wrData;
  end

  // registered read port; an empty read returns zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.pop)      rdData <= store[rdAddr];
    else if (strobe.popEmpty) rdData <= '0;
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popEmpty && !strobe.pop |=> rdData == '0); // R4
endmodule

// File: rtl/capture_fifo_ctrl.sv
module capture_fifo_ctrl
  import capture_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = CF_DEPTH,
  parameter int unsigned THR_W = CF_THR_W,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic                  dmaEnable,
  input  logic [THR_W-1:0]      thrCode,
  output dpStrobe_t             strobe,
  output logic [PTR_W-1:0]      wrPtr,
  output logic [PTR_W-1:0]      rdPtr,
  output logic [LVL_W-1:0]      level,
  output logic [LVL_W-1:0]      peakLevel,
  output logic                  dmaReq,
  output logic [CF_NUM_EVT-1:0] evtRaw
);
  logic             isFull, isEmpty, acceptWr, acceptRd, atThresh;
  logic [LVL_W-1:0] thrLevel, levelNext;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign isFull   = (level == LVL_W'(DEPTH));
  assign isEmpty  = (level == '0);
  assign acceptWr = wrEn && !isFull;
  assign acceptRd = rdEn && !isEmpty;

  // the threshold code is stored one below the word count it stands for
  assign thrLevel = LVL_W'(thrCode) + LVL_W'(1);
  assign atThresh = (level >= thrLevel);
  assign dmaReq   = dmaEnable && atThresh;

  always_comb begin
    unique case ({acceptWr, acceptRd})
      2'b10:   levelNext = level + LVL_W'(1);
      2'b01:   levelNext = level - LVL_W'(1);
      default: levelNext = level;
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.push     = acceptWr;
    strobe.pop      = acceptRd;
    strobe.popEmpty = rdEn && isEmpty;
  end

  always_comb begin
    evtRaw              = '0;
    evtRaw[EV_OVERFLOW]  = wrEn && isFull;
    evtRaw[EV_UNDERFLOW] = rdEn && isEmpty;
    evtRaw[EV_FULL]      = isFull;
    evtRaw[EV_THRESH]    = atThresh;
    evtRaw[EV_NONEMPTY]  = !isEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      level     <= '0;
      peakLevel <= '0;
    end else begin
      if (acceptWr) wrPtr <= bump(wrPtr);
      if (acceptRd) rdPtr <= bump(rdPtr);
      level <= levelNext;
      if (levelNext > peakLevel) peakLevel <= levelNext;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_W'(DEPTH)) && wrEn && !rdEn |=> (level == LVL_W'(DEPTH)) && $stable(wrPtr)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) && rdEn && !wrEn |=> (level == '0) && $stable(rdPtr)); // R4
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rstN)
    PTR_W'(wrPtr - rdPtr) == level[PTR_W-1:0]); // R5
  AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    peakLevel >= level); // R6
  AST_PEAK_MONO: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> peakLevel >= $past(peakLevel)); // R6
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |-> !dmaReq); // R7
endmodule

// File: rtl/capture_fifo_irq.sv
module capture_fifo_irq
  import capture_fifo_pkg::*;
#(
  parameter int unsigned NUM_EVT = CF_NUM_EVT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtRaw,
  input  logic [NUM_EVT-1:0] evtClear,
  input  logic [NUM_EVT-1:0] evtEnable,
  output logic [NUM_EVT-1:0] evtPending,
  output logic               irq
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    // an event in the same cycle as its clear keeps the bit set
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtPending[i] <= 1'b0;
      else       evtPending[i] <= evtRaw[i] || (evtPending[i] && !evtClear[i]);
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      evtPending[i] && !evtClear[i] |=> evtPending[i]); // R9
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
      evtRaw[i] |=> evtPending[i]); // R9
  end

  assign irq = |(evtPending & evtEnable);
endmodule

// File: rtl/capture_fifo.sv
module capture_fifo
  import capture_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        rdEn,
  output logic [31:0] rdData,
  input  logic        dmaEnable,
  input  logic [6:0]  thrCode,
  output logic        dmaReq,
  output logic [6:0]  wrPtr,
  output logic [6:0]  rdPtr,
  output logic [7:0]  level,
  output logic [7:0]  peakLevel,
  input  logic [4:0]  evtClear,
  input  logic [4:0]  evtEnable,
  output logic [4:0]  evtPending,
  output logic        irq
);
  dpStrobe_t             strobe;
  logic [CF_NUM_EVT-1:0] evtRaw;

  capture_fifo_ctrl #(.DEPTH(CF_DEPTH), .THR_W(CF_THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .dmaEnable(dmaEnable), .thrCode(thrCode), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .level(level), .peakLevel(peakLevel),
    .dmaReq(dmaReq), .evtRaw(evtRaw)
  );

  capture_fifo_dp #(.DEPTH(CF_DEPTH), .DATA_W(CF_DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrPtr),
    .rdAddr(rdPtr), .wrData(wrData), .rdData(rdData)
  );

  capture_fifo_irq #(.NUM_EVT(CF_NUM_EVT)) u_irq (
    .clk(clk), .rstN(rstN), .evtRaw(evtRaw), .evtClear(evtClear),
    .evtEnable(evtEnable), .evtPending(evtPending), .irq(irq)
  );
endmodule

// File: tb/capture_fifo_bench.sv
module capture_fifo_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, dmaEnable = 1'b0;
  logic [31:0] wrData = '0;
  logic [6:0]  thrCode = '0;
  logic [4:0]  evtClear = '0, evtEnable = '0;
  logic [31:0] rdData;
  logic        dmaReq, irq;
  logic [6:0]  wrPtr, rdPtr;
  logic [7:0]  level, peakLevel;
  logic [4:0]  evtPending;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] model[$];
  int expWr = 0, expRd = 0;

  always #4 clk = ~clk;  // 125 MHz

  capture_fifo u_capture_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .dmaEnable(dmaEnable), .thrCode(thrCode), .dmaReq(dmaReq),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .level(level), .peakLevel(peakLevel),
    .evtClear(evtClear), .evtEnable(evtEnable), .evtPending(evtPending), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0;
    if (model.size() < 128) begin
      model.push_back(d);
      expWr = (expWr + 1) % 128;
    end
  endtask

  task automatic pop(output logic [31:0] d);
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    d = rdData;
    if (model.size() > 0) expRd = (expRd + 1) % 128;
  endtask

  task automatic clearAll();
    evtClear = 5'h1f;
    tick();
    evtClear = '0;
  endtask

  task automatic t_reset();
    chk("R1 level", level, 0);
    chk("R1 wrPtr", wrPtr, 0);
    chk("R1 rdPtr", rdPtr, 0);
    chk("R1 peak", peakLevel, 0);
    chk("R1 pending", evtPending, 0);
    chk("R1 rdData", rdData, 0);
    chk("R1 dmaReq", dmaReq, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    for (int i = 0; i < 5; i++) push(32'hA000_0000 + i);
    chk("R2 level after 5 writes", level, 5);
    chk("R5 wrPtr after 5 writes", wrPtr, expWr);
    chk("R6 peak after 5 writes", peakLevel, 5);
    for (int i = 0; i < 5; i++) begin
      pop(d);
      chk("R2 read order", d, model.pop_front());
    end
    chk("R2 level drained", level, 0);
    chk("R5 rdPtr after 5 reads", rdPtr, expRd);
    chk("R6 peak kept after drain", peakLevel, 5);
    // simultaneous read and write
    push(32'h1111_0001);
    wrEn = 1'b1; rdEn = 1'b1; wrData = 32'h1111_0002;
    tick();
    wrEn = 1'b0; rdEn = 1'b0;
    model.push_back(32'h1111_0002); expWr = (expWr + 1) % 128;
    expRd = (expRd + 1) % 128;
    chk("R2 level on read+write", level, 1);
    chk("R2 data on read+write", rdData, model.pop_front());
    pop(d);
    chk("R2 data after read+write", d, model.pop_front());
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    clearAll();
    thrCode = 7'd3; dmaEnable = 1'b1;
    for (int i = 0; i < 3; i++) push(32'hB000_0000 + i);
    chk("R7 no request below code+1", dmaReq, 0);
    chk("R8 threshold bit clear below code+1", evtPending[3], 0);
    push(32'hB000_0003);
    chk("R7 request at code+1", dmaReq, 1);
    dmaEnable = 1'b0;
    tick();
    chk("R7 request gated by disable", dmaReq, 0);
    chk("R8 threshold pending", evtPending[3], 1);
    for (int i = 0; i < 4; i++) begin
      pop(d);
      void'(model.pop_front());
    end
  endtask

  task automatic t_fill();
    logic [31:0] d;
    logic [6:0]  wrHold;
    clearAll();
    thrCode = 7'd127; dmaEnable = 1'b1;
    for (int i = 0; i < 127; i++) push(32'hC000_0000 + i);
    tick();
    chk("R7 no request at 127 with code 127", dmaReq, 0);
    chk("R8 full clear at 127", evtPending[2], 0);
    push(32'hC000_007F);
    chk("R2 level full", level, 128);
    chk("R7 request at 128", dmaReq, 1);
    tick();
    chk("R8 full/thresh/nonempty pending", evtPending & 5'b11100, 5'b11100);
    chk("R3 no overflow yet", evtPending[0], 0);
    wrHold = wrPtr;
    chk("R5 wrPtr wrapped", wrPtr, expWr);
    push(32'hDEAD_BEEF);
    chk("R3 level held", level, 128);
    chk("R3 wrPtr held", wrPtr, wrHold);
    chk("R3 overflow pending", evtPending[0], 1);
    chk("R6 peak 128", peakLevel, 128);
    for (int i = 0; i < 128; i++) begin
      pop(d);
      chk("R3 drained data excludes dropped word", d, model.pop_front());
    end
    chk("R5 rdPtr wrapped", rdPtr, expRd);
    chk("R6 peak kept", peakLevel, 128);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    logic [6:0]  rdHold;
    clearAll();
    rdHold = rdPtr;
    pop(d);
    chk("R4 empty read returns zero", d, 0);
    chk("R4 underflow pending", evtPending[1], 1);
    chk("R4 level held", level, 0);
    chk("R4 rdPtr held", rdPtr, rdHold);
  endtask

  task automatic t_clear();
    push(32'hE000_0001);
    tick();
    chk("R8 nonempty pending", evtPending[4], 1);
    evtClear = 5'b00000;
    tick();
    chk("R9 zero clear leaves bits", evtPending & 5'b10010, 5'b10010);
    evtClear = 5'b10010;
    tick();
    evtClear = '0;
    chk("R9 underflow cleared", evtPending[1], 0);
    chk("R9 event beats clear", evtPending[4], 1);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    evtEnable = 5'b00000;
    #1;
    chk("R10 masked pending gives no irq", irq, 0);
    evtEnable = 5'b10000;
    #1;
    chk("R10 enabled nonempty raises irq", irq, 1);
    evtEnable = 5'b00010;
    #1;
    chk("R10 other bit disabled", irq, 0);
    pop(d);
    void'(model.pop_front());
    pop(d);
    chk("R10 underflow raises irq", irq, 1);
    evtClear = 5'b00010;
    tick();
    evtClear = '0;
    chk("R10 irq drops after clear", irq, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    tick();
    t_order();
    t_thresh();
    t_fill();
    t_underflow();
    t_clear();
    t_irq();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule